// File: doc/BRIEF.md
# Register-Array Page Table Translator

This block converts 16-bit virtual addresses into 15-bit physical addresses. The page table sits entirely in on-chip flops, with one entry for each of the 16 virtual pages. A translation therefore needs no memory read. On a context switch, software rewrites the table one entry per clock through a load port.

A translate request presents a virtual address together with a valid strobe. On the next cycle the block answers in one of two ways:

- If the indexed entry is marked present, it pulses an address-valid flag and holds the assembled physical address in an output register.
- If the entry is absent, it pulses a fault flag and drives no new address.

Fault servicing, frame allocation and translation caching belong to the surrounding system.

Top module: `pt_mmu`

## Requirements
- R1: After reset no response flag is high, `pa_o` is 0, and every entry is absent, so any translation issued before a load returns a fault.
- R2: A cycle with `ld_we_i` high writes `ld_present_i` and `ld_frame_i` into the entry selected by `ld_idx_i`. Exactly one entry is written per clock.
- R3: A request sampled with `xl_valid_i` high produces exactly one response, either `pa_valid_o` or `fault_o`, in the following cycle. Without a request both flags stay low.
- R4: When the indexed entry is present, `pa_valid_o` pulses and `pa_o` equals the entry's 3-bit frame number in bits 14:12, concatenated with the request's offset.
- R5: When the indexed entry is absent, `fault_o` pulses, `pa_valid_o` stays low, and `pa_o` keeps its previous value.
- R6: `pa_valid_o` and `fault_o` are never high in the same cycle.
- R7: The virtual page number is bits 15:12 of `xl_vaddr_i`. The offset is bits 11:0 and is copied unchanged into bits 11:0 of `pa_o`.
- R8: When a load and a translate hit the same entry in the same cycle, the translation uses the entry contents from before that write.
- R9: Rewriting an entry, including clearing its present bit, takes effect for the next translation of that page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ld_we_i | input | 1 | Entry write strobe |
| ld_idx_i | input | 4 | Entry index to write |
| ld_present_i | input | 1 | Present bit to write |
| ld_frame_i | input | 3 | Frame number to write |
| xl_valid_i | input | 1 | Translate request strobe |
| xl_vaddr_i | input | 16 | Virtual address to translate |
| pa_valid_o | output | 1 | Physical address valid pulse |
| pa_o | output | 15 | Registered physical address |
| fault_o | output | 1 | Page fault pulse |

## Verification
The bench goes after translations issued before any load. A design that fails to clear the present bits at reset would return addresses instead of faults.

It also issues a load and a translate to the same page in the same cycle. A write-first read path would then report the new frame, or fault one cycle early.

After every fault the bench checks that `pa_o` is unchanged. A design that loads the output register on a miss would leak a bogus address. It also checks that offsets with every bit pattern pass through intact, and that clearing an entry later turns a hit into a fault.

// File: rtl/pt_mmu_pkg.sv
package pt_mmu_pkg;
  parameter int unsigned VA_W      = 16;
  parameter int unsigned OFF_W     = 12;
  parameter int unsigned FRAME_W   = 3;
  localparam int unsigned VPN_W    = VA_W - OFF_W;
  localparam int unsigned ENTRIES  = 1 << VPN_W;
  localparam int unsigned PA_W     = FRAME_W + OFF_W;

  typedef struct packed {
    logic               present;
    logic [FRAME_W-1:0] frame;
  } pte_t;
endpackage

// File: rtl/pt_entry_array.sv
module pt_entry_array
  import pt_mmu_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [VPN_W-1:0] widx_i,
  input  pte_t             wdata_i,
  input  logic [VPN_W-1:0] ridx_i,
  output pte_t             rdata_o
);
  pte_t ent_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   ent_q[g] <= '0;
      else if (we_i && widx_i == VPN_W'(g))          ent_q[g] <= wdata_i;
    end

    // R2: a write lands in the addressed entry and nowhere else
    p_write_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && widx_i == VPN_W'(g)) |=> ent_q[g] == $past(wdata_i));
    p_untouched_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_i && widx_i == VPN_W'(g)) |=> $stable(ent_q[g]));
  end

  // read returns pre-write contents (R8)
  assign rdata_o = ent_q[ridx_i];
endmodule

// File: rtl/pt_addr_build.sv
module pt_addr_build
  import pt_mmu_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [OFF_W-1:0] off_i,
  input  pte_t             pte_i,
  output logic             pa_valid_o,
  output logic [PA_W-1:0]  pa_o,
  output logic             fault_o
);
  logic hit;
  assign hit = req_i & pte_i.present;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pa_valid_o <= 1'b0;
      fault_o    <= 1'b0;
      pa_o       <= '0;
    end else begin
      pa_valid_o <= hit;
      fault_o    <= req_i & ~pte_i.present;
      if (hit) pa_o <= {pte_i.frame, off_i};
    end
  end

  p_one_resp_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (pa_valid_o ^ fault_o));
  p_no_spurious_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !(pa_valid_o || fault_o));
  p_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pa_valid_o && fault_o));
  p_hold_on_fault_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> $stable(pa_o));
  p_offset_pass_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (pa_valid_o -> pa_o[OFF_W-1:0] == $past(off_i)));
endmodule

// File: rtl/pt_mmu.sv
module pt_mmu
  import pt_mmu_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_we_i,
  input  logic [VPN_W-1:0] ld_idx_i,
  input  logic             ld_present_i,
  input  logic [FRAME_W-1:0] ld_frame_i,
  input  logic             xl_valid_i,
  input  logic [VA_W-1:0]  xl_vaddr_i,
  output logic             pa_valid_o,
  output logic [PA_W-1:0]  pa_o,
  output logic             fault_o
);
  pte_t             wdata, rdata;
  logic [VPN_W-1:0] vpn;
  logic [OFF_W-1:0] off;

  assign wdata = '{present: ld_present_i, frame: ld_frame_i};
  assign vpn   = xl_vaddr_i[VA_W-1:OFF_W];
  assign off   = xl_vaddr_i[OFF_W-1:0];

  pt_entry_array u_tbl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (ld_we_i),
    .widx_i (ld_idx_i),
    .wdata_i(wdata),
    .ridx_i (vpn),
    .rdata_o(rdata)
  );

  pt_addr_build u_pa (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (xl_valid_i),
    .off_i     (off),
    .pte_i     (rdata),
    .pa_valid_o(pa_valid_o),
    .pa_o      (pa_o),
    .fault_o   (fault_o)
  );

  // R4: frame bits come from the entry written for that page
  p_frame_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xl_valid_i && rdata.present) |=> (pa_valid_o && pa_o[PA_W-1:OFF_W] == $past(rdata.frame)));
endmodule

// File: tb/sim_pt_mmu.sv
`timescale 1ns/1ps
module sim_pt_mmu;
  logic        clk = 0, rst_n = 0;
  logic        ld_we = 0, ld_present = 0, xl_valid = 0;
  logic [3:0]  ld_idx = 0;
  logic [2:0]  ld_frame = 0;
  logic [15:0] xl_vaddr = 0;
  logic        pa_valid, fault;
  logic [14:0] pa;

  int total = 0, bad = 0;
  bit m_pres [16];
  logic [2:0] m_frame [16];
  logic [14:0] m_pa = '0;
  bit done = 0;

  always #10 clk = ~clk;

  pt_mmu u0 (
    .clk_i(clk), .rst_ni(rst_n), .ld_we_i(ld_we), .ld_idx_i(ld_idx),
    .ld_present_i(ld_present), .ld_frame_i(ld_frame), .xl_valid_i(xl_valid),
    .xl_vaddr_i(xl_vaddr), .pa_valid_o(pa_valid), .pa_o(pa), .fault_o(fault)
  );

  function automatic logic [14:0] exp_pa(input logic [15:0] va);
    return {m_frame[va[15:12]], va[11:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic [3:0] i, input bit p, input logic [2:0] f);
    ld_we = 1; ld_idx = i; ld_present = p; ld_frame = f;
    @(negedge clk);
    ld_we = 0;
    m_pres[i] = p; m_frame[i] = f;
  endtask

  // issue one request, check response one cycle later
  task automatic xlate(input logic [15:0] va);
    bit hit;
    hit = m_pres[va[15:12]];
    xl_valid = 1; xl_vaddr = va;
    @(negedge clk);
    xl_valid = 0;
    if (hit) m_pa = exp_pa(va);
    chk(hit ? "R4" : "R5", {pa_valid, fault}, hit ? 2'b10 : 2'b01);
    chk(hit ? "R4/R7" : "R5 hold", pa, m_pa);
    if (pa_valid && fault) chk("R6", 1, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 16; i++) begin m_pres[i] = 0; m_frame[i] = 0; end
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 flags", {pa_valid, fault}, 0);
    chk("R1 pa", pa, 0);
    for (int i = 0; i < 16; i++) xlate({i[3:0], 12'hABC});   // R1: all fault

    // R2/R4/R7 directed
    load(4'h0, 1, 3'h5);
    load(4'hF, 1, 3'h7);
    xlate(16'h0FFF);
    xlate(16'hF000);
    xlate(16'hF555);
    xlate(16'h1234);                          // R5 absent, pa held
    @(negedge clk);
    chk("R3 idle", {pa_valid, fault}, 0);

    // R8: same-cycle load and translate on page 3 (absent -> present)
    ld_we = 1; ld_idx = 4'h3; ld_present = 1; ld_frame = 3'h2;
    xl_valid = 1; xl_vaddr = 16'h3AAA;
    @(negedge clk);
    ld_we = 0; xl_valid = 0;
    chk("R8 old entry", {pa_valid, fault}, 2'b01);
    chk("R8 pa held", pa, m_pa);
    m_pres[3] = 1; m_frame[3] = 3'h2;
    xlate(16'h3AAA);                          // R9 new entry visible

    // R9: clear present bit turns hit into fault
    load(4'h0, 0, 3'h5);
    xlate(16'h0123);

    // random mix
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 2) == 0)
        load(4'($urandom_range(0, 15)), bit'($urandom_range(0, 1)), 3'($urandom_range(0, 7)));
      else
        xlate(16'($urandom));
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hang exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule